// File: doc/BRIEF.md
# Pipelined Counter-Mixing Random Word Generator

This block produces one 32-bit pseudo-random word on every enabled clock. A free-running 32-bit counter is its only source of variation. The inverted count passes through a chain of registered nibble-mixing rounds, and the result serves as a per-count key. The count itself is delayed to line up with that key and XORed with it. It then passes through a second chain of mixing rounds. A final shift-add and shift-xor transform gives the output word.

All stages are registered, so throughput equals the counter rate. A single entropy bit can be folded into the counter to break the deterministic sequence. With that bit held low, the output stream is a fixed function of the count. This makes the block reproducible for test and simulation use.

Top module: `rng_word_gen`

## Requirements
- R1: While rst_ni is low, word_o is 0 and valid_o is 0, and the counter restarts at 0.
- R2: valid_o rises on exactly the 9th enabled clock after reset and then stays high. Before that, word_o is 0.
- R3: With ent_i low, the counter advances by 1 on each enabled clock. After the n-th enabled clock (n >= 9), word_o = F(n-9), so one new word is produced per enabled clock.
- R4: One round maps a word of eight nibbles, with nibble 0 in bits 3:0, as n'[i] = n[i] ^ n[(i+1)%8] ^ rotl1(n[(i+3)%8]). Here rotl1 is a 1-bit left rotate within the nibble. For count c, the key is four rounds applied to ~c.
- R5: F(c) takes d = c ^ key and applies four rounds to it, giving x. It then computes y = x + (x << 7) mod 2^32, and the result is y ^ (y >> 11).
- R6: While en_i is low, word_o, valid_o and every internal stage hold. No count value is skipped across a pause.
- R7: On an enabled clock with ent_i high, the next count is (count ^ 1) + 1 instead of count + 1.
- R8: Asserting rst_ni mid-run clears word_o and valid_o at once, without waiting for a clock edge. After release the fill sequence of R2 repeats from count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance counter and pipeline |
| ent_i | input | 1 | Entropy bit folded into the counter LSB |
| word_o | output | 32 | Generated word |
| valid_o | output | 1 | word_o holds a generated value |

## Verification
The bench counts enabled clocks during fill. A design whose latency is one stage off would raise valid_o early or late, or present the word for a neighbouring count. It inserts pauses in the middle of the stream: a stage that ignores en_i would drift out of alignment with the key path, and the words after the pause would no longer match F of consecutive counts. Entropy pulses are applied on both even and odd counts. An odd count makes the counter stand still for a cycle, which exposes an increment placed before the XOR. A reset is asserted between clock edges to catch a synchronous clear.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned NIB_W = 4;

  function automatic logic [NIB_W-1:0] rotl_nib(input logic [NIB_W-1:0] v);
    return {v[NIB_W-2:0], v[NIB_W-1]};
  endfunction
endpackage

// File: rtl/rng_ctr.sv
module rng_ctr #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ent_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= (cnt_q ^ {{(WIDTH-1){1'b0}}, ent_i}) + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !ent_i |=> cnt_o == $past(cnt_o) + 1'b1);  // R3
  AST_CTR_ENT_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ent_i && !cnt_o[0] |=> cnt_o == $past(cnt_o) + 2'd2);  // R7
  AST_CTR_ENT_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ent_i && cnt_o[0] |=> $stable(cnt_o));  // R7
  AST_CTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o));  // R6
endmodule

// File: rtl/rng_round_stage.sv
module rng_round_stage
  import rng_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] x_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] x_o
);
  localparam int unsigned N_NIB = WIDTH / NIB_W;

  logic [WIDTH-1:0] rnd;
  logic [WIDTH-1:0] x_q;
  logic             vld_q;

  for (genvar i = 0; i < N_NIB; i++) begin : g_nib
    localparam int unsigned J = (i + 1) % N_NIB;
    localparam int unsigned K = (i + 3) % N_NIB;
    assign rnd[i*NIB_W +: NIB_W] = x_i[i*NIB_W +: NIB_W]
                                 ^ x_i[J*NIB_W +: NIB_W]
                                 ^ rotl_nib(x_i[K*NIB_W +: NIB_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      vld_q <= 1'b0;
    end else if (en_i) begin
      x_q   <= rnd;
      vld_q <= vld_i;
    end
  end

  assign x_o   = x_q;
  assign vld_o = vld_q;

  AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(x_o) && $stable(vld_o));  // R6
  AST_STAGE_VLD_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> vld_o);  // R2
endmodule

// File: rtl/rng_delay.sv
module rng_delay #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] sr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
    end else if (en_i) begin
      sr_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign d_o = sr_q[DEPTH-1];

  AST_DLY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(d_o));  // R6
endmodule

// File: rtl/rng_lin_out.sv
module rng_lin_out #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned SH_ADD = 7,
  parameter int unsigned SH_XOR = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] x_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] mix;
  logic [WIDTH-1:0] word_q;
  logic             vld_q;

  assign sum = x_i + (x_i << SH_ADD);
  assign mix = sum ^ (sum >> SH_XOR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else if (en_i) begin
      word_q <= mix;
      vld_q  <= vld_i;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  AST_ZERO_UNTIL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> word_o == '0);  // R2
endmodule

// File: rtl/rng_word_gen.sv
module rng_word_gen #(
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned KEY_ROUNDS = 4,
  parameter int unsigned MIX_ROUNDS = 4,
  parameter int unsigned SH_ADD     = 7,
  parameter int unsigned SH_XOR     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ent_i,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] cnt_dly;
  logic [WIDTH-1:0] key_c [KEY_ROUNDS+1];
  logic             key_v [KEY_ROUNDS+1];
  logic [WIDTH-1:0] mix_c [MIX_ROUNDS+1];
  logic             mix_v [MIX_ROUNDS+1];

  rng_ctr #(.WIDTH(WIDTH)) u_ctr (
    .clk_i, .rst_ni, .en_i, .ent_i, .cnt_o(cnt)
  );

  // key path: rounds over the inverted count
  assign key_c[0] = ~cnt;
  assign key_v[0] = 1'b1;

  for (genvar g = 0; g < KEY_ROUNDS; g++) begin : g_key
    rng_round_stage #(.WIDTH(WIDTH)) u_stage (
      .clk_i, .rst_ni, .en_i,
      .vld_i(key_v[g]),   .x_i(key_c[g]),
      .vld_o(key_v[g+1]), .x_o(key_c[g+1])
    );
  end

  // align the count with its key
  rng_delay #(.WIDTH(WIDTH), .DEPTH(KEY_ROUNDS)) u_dly (
    .clk_i, .rst_ni, .en_i, .d_i(cnt), .d_o(cnt_dly)
  );

  assign mix_c[0] = cnt_dly ^ key_c[KEY_ROUNDS];
  assign mix_v[0] = key_v[KEY_ROUNDS];

  for (genvar g = 0; g < MIX_ROUNDS; g++) begin : g_mix
    rng_round_stage #(.WIDTH(WIDTH)) u_stage (
      .clk_i, .rst_ni, .en_i,
      .vld_i(mix_v[g]),   .x_i(mix_c[g]),
      .vld_o(mix_v[g+1]), .x_o(mix_c[g+1])
    );
  end

  rng_lin_out #(.WIDTH(WIDTH), .SH_ADD(SH_ADD), .SH_XOR(SH_XOR)) u_out (
    .clk_i, .rst_ni, .en_i,
    .vld_i(mix_v[MIX_ROUNDS]), .x_i(mix_c[MIX_ROUNDS]),
    .vld_o(valid_o), .word_o(word_o)
  );

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);  // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(word_o) && $stable(valid_o));  // R6
  AST_KEY_BEFORE_MIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix_v[1] |-> key_v[KEY_ROUNDS]);  // R5
endmodule

// File: tb/rng_word_gen_tb.sv
module rng_word_gen_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        ent_i = 1'b0;
  logic [31:0] word_o;
  logic        valid_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] hist [0:255];
  int          n_en = 0;
  logic [31:0] ref_cnt = '0;

  rng_word_gen u_dut (
    .clk_i, .rst_ni, .en_i, .ent_i, .word_o, .valid_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic [31:0] ref_round(input logic [31:0] x);
    logic [31:0] y;
    logic [3:0]  a, b, c;
    for (int i = 0; i < 8; i++) begin
      a = x[i*4 +: 4];
      b = x[((i+1)%8)*4 +: 4];
      c = x[((i+3)%8)*4 +: 4];
      y[i*4 +: 4] = a ^ b ^ {c[2:0], c[3]};
    end
    return y;
  endfunction

  function automatic logic [31:0] ref_f(input logic [31:0] c);
    logic [31:0] k, d, y;
    k = ~c;
    for (int r = 0; r < 4; r++) k = ref_round(k);   // R4
    d = c ^ k;
    for (int r = 0; r < 4; r++) d = ref_round(d);   // R5
    y = d + (d << 7);
    return y ^ (y >> 11);
  endfunction

  task automatic check(input string req, input logic exp_v, input logic [31:0] exp_w);
    tests++;
    if (valid_o !== exp_v || word_o !== exp_w) begin
      fails++;
      $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
               req, valid_o, word_o, exp_v, exp_w);
    end
  endtask

  task automatic check_model(input string req);
    if (n_en >= 9) check(req, 1'b1, ref_f(hist[n_en-9]));
    else           check(req, 1'b0, 32'h0);
  endtask

  // one clock; inputs change 1 time unit after the edge
  task automatic cyc(input logic en, input logic ent);
    en_i  = en;
    ent_i = ent;
    @(posedge clk_i);
    #1;
    if (en) begin
      hist[n_en] = ref_cnt;
      n_en++;
      ref_cnt = (ref_cnt ^ {31'b0, ent}) + 1;
    end
    en_i  = 1'b0;
    ent_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset", 1'b0, 32'h0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0);
      check("R2 fill", 1'b0, 32'h0);
    end
    cyc(1'b1, 1'b0);
    check("R2 first valid", 1'b1, ref_f(32'h0));
  endtask

  task automatic t_stream;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b0);
      check_model("R3 R4 R5 stream");
    end
  endtask

  task automatic t_pause;
    logic [31:0] held;
    held = word_o;
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b1);
      check("R6 hold", 1'b1, held);
    end
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 1'b0);
      check_model("R6 resume");
      cyc(1'b0, 1'b0);
      check_model("R6 gap");
    end
  endtask

  task automatic t_entropy;
    // one pulse on an even count, one on an odd count
    if (ref_cnt[0]) cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    check_model("R7 even");
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    check_model("R7 odd");
    for (int i = 0; i < 12; i++) begin
      cyc(1'b1, 1'b0);
      check_model("R7 after");
    end
  endtask

  task automatic t_async_reset;
    cyc(1'b1, 1'b0);
    #2;
    rst_ni = 1'b0;
    #1;
    check("R8 async clear", 1'b0, 32'h0);
    @(posedge clk_i);
    #1;
    rst_ni  = 1'b1;
    n_en    = 0;
    ref_cnt = '0;
    check("R8 after release", 1'b0, 32'h0);
    for (int i = 0; i < 12; i++) begin
      cyc(1'b1, 1'b0);
      check_model("R8 refill");
    end
  endtask

  initial begin
    #(CLK_P*50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    t_reset;
    rst_ni = 1'b1;
    #1;
    t_reset;
    t_fill;
    t_stream;
    t_pause;
    t_entropy;
    t_async_reset;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule